// File: doc/BRIEF.md
# BCD Calendar Time Counter

This block holds the time of day and the calendar date as packed BCD fields. Each cycle in which the one-second enable is high moves the time forward by one second. Carries ripple through minutes, hours, day of week, date, month and the two-digit year. The block also keeps a century flag that can be switched on or off. The prescaler that makes the one-second enable sits outside the block, and so does any bus interface.

Software or a controller sets the time with a parallel load. A single-cycle strobe overwrites every field at once. A stop input freezes the count, for example while the time is being read or prepared. The block picks the length of each month by itself. It counts a year as a leap year whenever the two-digit year is divisible by four, which gives correct dates up to the year 2100.

Top module: `bcd_calendar_counter`

## Requirements
- R1: While reset is asserted, and after it is released, seconds, minutes, hours and year read 0x00, day of week, date and month read 0x01, and the century flag reads 0.
- R2: Seconds count 0x00 to 0x59 and minutes count 0x00 to 0x59. Each wraps to 0x00 and carries into the next field. Hours count 0x00 to 0x23 and carry into the day when they wrap.
- R3: Day of week counts 0x01 to 0x07 and wraps to 0x01. It advances on the same tick that advances the date at midnight, and on no other tick.
- R4: Date wraps to 0x01 and month advances after day 0x30 in months 0x04, 0x06, 0x09 and 0x11, after day 0x31 in the other months, and after day 0x28 in February of a non-leap year.
- R5: February runs to 0x29 when the BCD year is divisible by four. That is the case when the tens digit is even and the units digit is 0, 4 or 8, or when the tens digit is odd and the units digit is 2 or 6.
- R6: Month wraps from 0x12 to 0x01 and advances the year. Year wraps from 0x99 to 0x00.
- R7: When the year wraps from 0x99 to 0x00 and century enable is 1, the century flag inverts. When century enable is 0, the flag keeps its value.
- R8: While stop is 1, ticks have no effect and no field changes.
- R9: A load strobe writes every field, including the century flag, from the load inputs on the next clock edge. A tick in the same cycle is dropped.
- R10: A cycle with no tick and no load leaves all fields unchanged. Each accepted tick advances the time by exactly one second.
- R11: Starting from valid values, every field remains valid BCD within its legal range.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | One-second enable pulse |
| stop | input | 1 | Freeze counting when 1 |
| centuryEn | input | 1 | Allow the century flag to toggle at year wrap |
| load | input | 1 | Single-cycle parallel load strobe |
| loadSec | input | 8 | BCD seconds to load |
| loadMin | input | 8 | BCD minutes to load |
| loadHour | input | 8 | BCD hours to load |
| loadDow | input | 8 | BCD day of week to load |
| loadDate | input | 8 | BCD date to load |
| loadMonth | input | 8 | BCD month to load |
| loadYear | input | 8 | BCD year to load |
| loadCentury | input | 1 | Century flag to load |
| secOut | output | 8 | BCD seconds |
| minOut | output | 8 | BCD minutes |
| hourOut | output | 8 | BCD hours |
| dowOut | output | 8 | BCD day of week |
| dateOut | output | 8 | BCD date |
| monthOut | output | 8 | BCD month |
| yearOut | output | 8 | BCD year |
| centuryOut | output | 1 | Century flag |

## Verification
A load strobe and a tick can arrive in the same cycle, and so can a tick and the stop input. Directed cases raise load and tick together. They expect exactly the loaded values, with no second added. Other cases hold stop high across several ticks and expect every field to stay frozen. The random phase mixes ticks, stops and loads that land near the carry boundaries. A bench model in plain integers predicts every field after every edge, giving the load priority over the tick.

// File: rtl/bcd_cal_pkg.sv
package bcd_cal_pkg;
  localparam int DIGIT_W = 4;
  localparam int FIELD_W = 2 * DIGIT_W;

  typedef logic [FIELD_W-1:0] bcdField_t;

  localparam bcdField_t SEC_MAX   = 8'h59;
  localparam bcdField_t MIN_MAX   = 8'h59;
  localparam bcdField_t HOUR_MAX  = 8'h23;
  localparam bcdField_t DOW_MAX   = 8'h07;
  localparam bcdField_t MONTH_MAX = 8'h12;
  localparam bcdField_t YEAR_MAX  = 8'h99;
  localparam bcdField_t ZERO_VAL  = 8'h00;
  localparam bcdField_t ONE_VAL   = 8'h01;

  typedef struct packed {
    bcdField_t sec;
    bcdField_t min;
    bcdField_t hour;
    bcdField_t dow;
    bcdField_t date;
    bcdField_t month;
    bcdField_t year;
    logic      century;
  } calTime_t;

  typedef struct packed {
    logic loadAll;
    logic advSec;
    logic advMin;
    logic advHour;
    logic advDay;
    logic advMonth;
    logic advYear;
    logic wrapSec;
    logic wrapMin;
    logic wrapHour;
    logic wrapDow;
    logic wrapDate;
    logic wrapMonth;
    logic wrapYear;
    logic flipCentury;
  } calStrobe_t;

  function automatic bcdField_t bcdInc(bcdField_t v);
    logic [DIGIT_W-1:0] lo;
    logic [DIGIT_W-1:0] hi;
    lo = v[DIGIT_W-1:0];
    hi = v[FIELD_W-1:DIGIT_W];
    if (lo >= 4'd9) begin
      lo = '0;
      hi = hi + 4'd1;
    end else begin
      lo = lo + 4'd1;
    end
    return {hi, lo};
  endfunction

  function automatic logic leapYear(bcdField_t y);
    logic [DIGIT_W-1:0] lo;
    lo = y[DIGIT_W-1:0];
    if (y[DIGIT_W] == 1'b0)
      return (lo == 4'd0) || (lo == 4'd4) || (lo == 4'd8);
    else
      return (lo == 4'd2) || (lo == 4'd6);
  endfunction

  function automatic bcdField_t monthEnd(bcdField_t m, bcdField_t y);
    case (m)
      8'h02:                      return leapYear(y) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction
endpackage

// File: rtl/bcd_cal_control.sv
module bcd_cal_control
  import bcd_cal_pkg::*;
(
  input  logic       tick,
  input  logic       stop,
  input  logic       load,
  input  logic       centuryEn,
  input  calTime_t   cur,
  output calStrobe_t st
);
  always_comb begin
    st = '0;
    st.loadAll   = load;
    st.advSec    = tick && !stop && !load;
    st.wrapSec   = cur.sec >= SEC_MAX;
    st.wrapMin   = cur.min >= MIN_MAX;
    st.wrapHour  = cur.hour >= HOUR_MAX;
    st.wrapDow   = cur.dow >= DOW_MAX;
    st.wrapDate  = cur.date >= monthEnd(cur.month, cur.year);
    st.wrapMonth = cur.month >= MONTH_MAX;
    st.wrapYear  = cur.year >= YEAR_MAX;
    st.advMin    = st.advSec && st.wrapSec;
    st.advHour   = st.advMin && st.wrapMin;
    st.advDay    = st.advHour && st.wrapHour;
    st.advMonth  = st.advDay && st.wrapDate;
    st.advYear   = st.advMonth && st.wrapMonth;
    st.flipCentury = st.advYear && st.wrapYear && centuryEn;
  end
endmodule

// File: rtl/bcd_cal_datapath.sv
module bcd_cal_datapath
  import bcd_cal_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  calStrobe_t st,
  input  calTime_t   loadVal,
  output calTime_t   cur
);
  localparam calTime_t RESET_VAL = '{sec: ZERO_VAL, min: ZERO_VAL, hour: ZERO_VAL,
                                     dow: ONE_VAL, date: ONE_VAL, month: ONE_VAL,
                                     year: ZERO_VAL, century: 1'b0};

  function automatic bcdField_t stepField(bcdField_t v, logic adv, logic wrap,
                                          bcdField_t low);
    if (!adv) return v;
    return wrap ? low : bcdInc(v);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur <= RESET_VAL;
    end else if (st.loadAll) begin
      cur <= loadVal;
    end else begin
      cur.sec   <= stepField(cur.sec,   st.advSec,   st.wrapSec,   ZERO_VAL);
      cur.min   <= stepField(cur.min,   st.advMin,   st.wrapMin,   ZERO_VAL);
      cur.hour  <= stepField(cur.hour,  st.advHour,  st.wrapHour,  ZERO_VAL);
      cur.dow   <= stepField(cur.dow,   st.advDay,   st.wrapDow,   ONE_VAL);
      cur.date  <= stepField(cur.date,  st.advDay,   st.wrapDate,  ONE_VAL);
      cur.month <= stepField(cur.month, st.advMonth, st.wrapMonth, ONE_VAL);
      cur.year  <= stepField(cur.year,  st.advYear,  st.wrapYear,  ZERO_VAL);
      if (st.flipCentury) cur.century <= !cur.century;
    end
  end
endmodule

// File: rtl/bcd_calendar_counter.sv
module bcd_calendar_counter
  import bcd_cal_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       stop,
  input  logic       centuryEn,
  input  logic       load,
  input  logic [7:0] loadSec,
  input  logic [7:0] loadMin,
  input  logic [7:0] loadHour,
  input  logic [7:0] loadDow,
  input  logic [7:0] loadDate,
  input  logic [7:0] loadMonth,
  input  logic [7:0] loadYear,
  input  logic       loadCentury,
  output logic [7:0] secOut,
  output logic [7:0] minOut,
  output logic [7:0] hourOut,
  output logic [7:0] dowOut,
  output logic [7:0] dateOut,
  output logic [7:0] monthOut,
  output logic [7:0] yearOut,
  output logic       centuryOut
);
  calTime_t   cur;
  calTime_t   loadVal;
  calStrobe_t st;

  assign loadVal = '{sec: loadSec, min: loadMin, hour: loadHour, dow: loadDow,
                     date: loadDate, month: loadMonth, year: loadYear,
                     century: loadCentury};

  bcd_cal_control u_control (
    .tick(tick), .stop(stop), .load(load), .centuryEn(centuryEn),
    .cur(cur), .st(st)
  );

  bcd_cal_datapath u_datapath (
    .clk(clk), .rst_n(rst_n), .st(st), .loadVal(loadVal), .cur(cur)
  );

  assign secOut     = cur.sec;
  assign minOut     = cur.min;
  assign hourOut    = cur.hour;
  assign dowOut     = cur.dow;
  assign dateOut    = cur.date;
  assign monthOut   = cur.month;
  assign yearOut    = cur.year;
  assign centuryOut = cur.century;
endmodule

// File: rtl/bcd_calendar_checker.sv
module bcd_calendar_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       tick,
  input logic       stop,
  input logic       centuryEn,
  input logic       load,
  input logic [7:0] loadSec,
  input logic [7:0] loadMin,
  input logic [7:0] loadHour,
  input logic [7:0] loadDow,
  input logic [7:0] loadDate,
  input logic [7:0] loadMonth,
  input logic [7:0] loadYear,
  input logic       loadCentury,
  input logic [7:0] secOut,
  input logic [7:0] minOut,
  input logic [7:0] hourOut,
  input logic [7:0] dowOut,
  input logic [7:0] dateOut,
  input logic [7:0] monthOut,
  input logic [7:0] yearOut,
  input logic       centuryOut
);
  logic [56:0] allOut;
  logic [56:0] allLoad;
  logic        loadsValid;
  logic        outsValid;

  assign allOut  = {secOut, minOut, hourOut, dowOut, dateOut, monthOut, yearOut, centuryOut};
  assign allLoad = {loadSec, loadMin, loadHour, loadDow, loadDate, loadMonth, loadYear,
                    loadCentury};

  function automatic logic inRange(logic [7:0] v, logic [7:0] lo, logic [7:0] hi);
    return (v[3:0] <= 4'd9) && (v >= lo) && (v <= hi);
  endfunction

  assign outsValid = inRange(secOut, 8'h00, 8'h59) && inRange(minOut, 8'h00, 8'h59) &&
                     inRange(hourOut, 8'h00, 8'h23) && inRange(dowOut, 8'h01, 8'h07) &&
                     inRange(dateOut, 8'h01, 8'h31) && inRange(monthOut, 8'h01, 8'h12) &&
                     inRange(yearOut, 8'h00, 8'h99);
  assign loadsValid = inRange(loadSec, 8'h00, 8'h59) && inRange(loadMin, 8'h00, 8'h59) &&
                      inRange(loadHour, 8'h00, 8'h23) && inRange(loadDow, 8'h01, 8'h07) &&
                      inRange(loadDate, 8'h01, 8'h31) && inRange(loadMonth, 8'h01, 8'h12) &&
                      inRange(loadYear, 8'h00, 8'h99);

  assert_load_all_R9: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> allOut == $past(allLoad));

  assert_stop_freeze_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (stop && !load) |=> $stable(allOut));

  assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !load) |=> $stable(allOut));

  assert_sec_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !stop && !load && secOut == 8'h59) |=> (secOut == 8'h00) && !$stable(minOut));

  assert_century_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!centuryEn && !load) |=> $stable(centuryOut));

  assert_dow_with_date_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> ($stable(dowOut) == $stable(dateOut)));

  assert_fields_valid_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (outsValid && (!load || loadsValid)) |=> outsValid);
endmodule

bind bcd_calendar_counter bcd_calendar_checker u_checker (
  .clk(clk), .rst_n(rst_n), .tick(tick), .stop(stop), .centuryEn(centuryEn),
  .load(load), .loadSec(loadSec), .loadMin(loadMin), .loadHour(loadHour),
  .loadDow(loadDow), .loadDate(loadDate), .loadMonth(loadMonth),
  .loadYear(loadYear), .loadCentury(loadCentury), .secOut(secOut),
  .minOut(minOut), .hourOut(hourOut), .dowOut(dowOut), .dateOut(dateOut),
  .monthOut(monthOut), .yearOut(yearOut), .centuryOut(centuryOut)
);

// File: tb/bcd_calendar_counter_bench.sv
module bcd_calendar_counter_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic rst_n, tick, stop, centuryEn, load, loadCentury, centuryOut;
  logic [7:0] loadSec, loadMin, loadHour, loadDow, loadDate, loadMonth, loadYear;
  logic [7:0] secOut, minOut, hourOut, dowOut, dateOut, monthOut, yearOut;

  bcd_calendar_counter u_bcd_calendar_counter (.*);

  int checks = 0;
  int fails = 0;
  int eS, eM, eH, eW, eD, eMo, eY, eC;
  int lS, lM, lH, lW, lD, lMo, lY, lC;

  function automatic logic [7:0] toBcd(int n);
    return 8'((n / 10) * 16 + (n % 10));
  endfunction

  function automatic int monthDays(int mo, int y);
    if (mo == 2) return (y % 4 == 0) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  function automatic logic [56:0] expVec();
    return {toBcd(eS), toBcd(eM), toBcd(eH), toBcd(eW), toBcd(eD), toBcd(eMo),
            toBcd(eY), eC[0]};
  endfunction

  task automatic compare(string tag);
    logic [56:0] act;
    act = {secOut, minOut, hourOut, dowOut, dateOut, monthOut, yearOut, centuryOut};
    checks++;
    if (act !== expVec()) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expVec());
    end
  endtask

  task automatic setLoad(int s, int m, int h, int w, int d, int mo, int y, int c);
    lS = s; lM = m; lH = h; lW = w; lD = d; lMo = mo; lY = y; lC = c;
    loadSec = toBcd(s); loadMin = toBcd(m); loadHour = toBcd(h); loadDow = toBcd(w);
    loadDate = toBcd(d); loadMonth = toBcd(mo); loadYear = toBcd(y); loadCentury = c[0];
  endtask

  task automatic modelAdvance(bit ce);
    eS++;
    if (eS == 60) begin
      eS = 0; eM++;
      if (eM == 60) begin
        eM = 0; eH++;
        if (eH == 24) begin
          eH = 0;
          eW = (eW == 7) ? 1 : eW + 1;
          eD++;
          if (eD > monthDays(eMo, eY)) begin
            eD = 1; eMo++;
            if (eMo == 13) begin
              eMo = 1; eY++;
              if (eY == 100) begin
                eY = 0;
                if (ce) eC = 1 - eC;
              end
            end
          end
        end
      end
    end
  endtask

  task automatic cycle(bit tk, bit st, bit ld, bit ce, string tag);
    @(negedge clk);
    tick = tk; stop = st; load = ld; centuryEn = ce;
    @(posedge clk);
    #1;
    if (ld) begin
      eS = lS; eM = lM; eH = lH; eW = lW; eD = lD; eMo = lMo; eY = lY; eC = lC;
    end else if (tk && !st) begin
      modelAdvance(ce);
    end
    compare(tag);
  endtask

  task automatic loadThenTick(int s, int m, int h, int w, int d, int mo, int y, int c,
                              bit ce, string tag);
    setLoad(s, m, h, w, d, mo, y, c);
    cycle(1'b0, 1'b0, 1'b1, ce, "R9 load");
    cycle(1'b1, 1'b0, 1'b0, ce, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1357));
    rst_n = 1'b0; tick = 0; stop = 0; load = 0; centuryEn = 0;
    setLoad(0, 0, 0, 1, 1, 1, 0, 0);
    eS = 0; eM = 0; eH = 0; eW = 1; eD = 1; eMo = 1; eY = 0; eC = 0;
    repeat (3) @(posedge clk);
    #1 compare("R1 during reset");
    @(negedge clk) rst_n = 1'b1;
    @(posedge clk); #1 compare("R1 after reset");

    cycle(1'b0, 1'b0, 1'b0, 1'b0, "R10 idle");
    cycle(1'b1, 1'b0, 1'b0, 1'b0, "R10 one tick");

    // full rollover with century enabled
    loadThenTick(58, 59, 23, 7, 31, 12, 99, 0, 1'b1, "R2 to 59");
    cycle(1'b1, 1'b0, 1'b0, 1'b1, "R2 R3 R6 R7 full rollover");
    // full rollover with century disabled
    loadThenTick(59, 59, 23, 3, 31, 12, 99, 1, 1'b0, "R7 century hold");
    // load and tick together: tick dropped
    setLoad(12, 34, 5, 2, 15, 6, 45, 0);
    cycle(1'b1, 1'b0, 1'b1, 1'b0, "R9 load with tick");
    // month lengths and leap years
    loadThenTick(59, 59, 23, 1, 28, 2, 24, 0, 1'b0, "R5 Feb28 y24");
    loadThenTick(59, 59, 23, 2, 29, 2, 24, 0, 1'b0, "R5 Feb29 y24");
    loadThenTick(59, 59, 23, 3, 28, 2, 23, 0, 1'b0, "R4 Feb28 y23");
    loadThenTick(59, 59, 23, 4, 28, 2, 12, 0, 1'b0, "R5 Feb28 y12");
    loadThenTick(59, 59, 23, 5, 28, 2, 10, 0, 1'b0, "R5 Feb28 y10");
    loadThenTick(59, 59, 23, 6, 30, 4, 10, 0, 1'b0, "R4 Apr30");
    loadThenTick(59, 59, 23, 6, 30, 1, 10, 0, 1'b0, "R4 Jan30");
    loadThenTick(59, 59, 23, 7, 31, 1, 10, 0, 1'b0, "R4 R3 Jan31");
    loadThenTick(59, 59, 22, 7, 11, 9, 37, 0, 1'b0, "R2 R3 hour carry");
    // stop freezes
    cycle(1'b1, 1'b1, 1'b0, 1'b0, "R8 stop");
    cycle(1'b1, 1'b1, 1'b0, 1'b1, "R8 stop");
    cycle(1'b1, 1'b0, 1'b0, 1'b0, "R10 resume");

    // random phase
    for (int i = 0; i < 4000; i++) begin
      bit ld, tk, st, ce;
      ld = ($urandom % 10) == 0;
      tk = ($urandom % 4) != 0;
      st = ($urandom % 6) == 0;
      ce = $urandom % 2;
      if (ld) begin
        int mo, y, near;
        mo = 1 + $urandom % 12;
        y = ($urandom % 3 == 0) ? 99 : $urandom % 100;
        near = $urandom % 2;
        setLoad(near ? 59 - $urandom % 2 : $urandom % 60,
                near ? 59 : $urandom % 60,
                near ? 23 : $urandom % 24,
                1 + $urandom % 7,
                near ? monthDays(mo, y) : 1 + $urandom % monthDays(mo, y),
                (near && ($urandom % 2 == 0)) ? 12 : mo,
                y, $urandom % 2);
      end
      cycle(tk, st, ld, ce, "R10 R11 random");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule